// File: doc/BRIEF.md
# Dual-Select Edge-Triggered Code Register Pair

This block gives a host on a 16-bit bus write access to two 12-bit converter codes, one per channel. The host places a 12-bit word on the data input, pulls low the select of each channel it wants to address, and pulses a common write strobe. On the rising edge of that strobe, the word lands in every channel whose select is low. With both selects low, one write loads the same word into both channels. Each channel has a single register, and that register drives its code output directly. No second load strobe is needed.

The strobe, the selects and the data arrive from outside the system clock domain. They pass through a chain of synchronizing flops, and a rising edge is detected on the synchronized strobe. The select and data values that are captured come from the same synchronized sample as the last low strobe sample. As a result, the host may release the select and change the data together with the rising strobe (zero hold). Data must be valid one synchronizer sample before the rising edge. This is the clock-domain version of the set-up window.

Top module: `twin_code_capture`

## Requirements
- R1: While reset is asserted (rst_n low), and on the first clock after it, both code outputs are 12'h000.
- R2: Codes change only on a rising edge of the write strobe. A strobe held low or held high loads nothing, even with a select low and the data changing.
- R3: At a rising strobe edge with sel_a_n = 0 and sel_b_n = 1, code_a takes the data word and code_b keeps its value.
- R4: At a rising strobe edge with sel_b_n = 0 and sel_a_n = 1, code_b takes the data word and code_a keeps its value.
- R5: At a rising strobe edge with both selects 0, both codes take the same data word.
- R6: At a rising strobe edge with both selects 1, neither code changes.
- R7: The loaded word and the channel selection are those present before the strobe rose. Data or selects that change in the same instant as the rising strobe do not affect that write.
- R8: With SYNC_STAGES = 2, a code changes on the third rising clock edge after the strobe first goes high, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_strobe | input | 1 | Write strobe; loads on its rising edge |
| sel_a_n | input | 1 | Active-low select for channel A |
| sel_b_n | input | 1 | Active-low select for channel B |
| wr_data | input | 12 | Data word to load |
| code_a | output | 12 | Channel A code |
| code_b | output | 12 | Channel B code |

## Verification
The hardest case to reach from the ports is a write in which the data and the selects move in the very same instant as the strobe rises. In that case only the alignment of the synchronized copies decides which word is loaded. The bench drives the strobe high, the data to a new value and the selects to swapped values in one time step. It then checks that the old word reached only the channel that was selected beforehand. A separate sequence holds the strobe high while the data keeps changing, which confirms that a level does not act as an edge.

// File: rtl/twin_code_capture.sv
module twin_code_capture #(
  parameter int WIDTH       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_strobe,
  input  logic             sel_a_n,
  input  logic             sel_b_n,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] code_a,
  output logic [WIDTH-1:0] code_b
);

  localparam int LAST = SYNC_STAGES;

  logic [LAST:0]      wr_q;
  logic [LAST:0]      sa_q;
  logic [LAST:0]      sb_q;
  logic [WIDTH-1:0]   dat_q [LAST+1];
  logic               wr_rise;
  logic               load_a;
  logic               load_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      sa_q <= '1;
      sb_q <= '1;
      for (int i = 0; i <= LAST; i++) dat_q[i] <= '0;
    end else begin
      wr_q <= {wr_q[LAST-1:0], wr_strobe};
      sa_q <= {sa_q[LAST-1:0], sel_a_n};
      sb_q <= {sb_q[LAST-1:0], sel_b_n};
      dat_q[0] <= wr_data;
      for (int i = 1; i <= LAST; i++) dat_q[i] <= dat_q[i-1];
    end
  end

  assign wr_rise = wr_q[LAST-1] & ~wr_q[LAST];
  assign load_a  = wr_rise & ~sa_q[LAST];
  assign load_b  = wr_rise & ~sb_q[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_a <= '0;
      code_b <= '0;
    end else begin
      if (load_a) code_a <= dat_q[LAST];
      if (load_b) code_b <= dat_q[LAST];
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (code_a == '0 && code_b == '0));

  p_no_edge_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_rise |=> ($stable(code_a) && $stable(code_b)));

  p_load_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && !sa_q[LAST]) |=> code_a == $past(dat_q[LAST]));

  p_load_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && !sb_q[LAST]) |=> code_b == $past(dat_q[LAST]));

  p_both_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && sa_q[LAST] && sb_q[LAST]) |=> ($stable(code_a) && $stable(code_b)));

  p_broadcast_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && !sa_q[LAST] && !sb_q[LAST]) |=> code_a == code_b);

endmodule

// File: tb/twin_code_capture_tb.sv
`timescale 1ns/1ps
module twin_code_capture_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_strobe = 1'b0;
  logic        sel_a_n = 1'b1;
  logic        sel_b_n = 1'b1;
  logic [11:0] wr_data = '0;
  logic [11:0] code_a;
  logic [11:0] code_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  twin_code_capture u_dut (
    .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe),
    .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .wr_data(wr_data),
    .code_a(code_a), .code_b(code_b)
  );

  // {sel_a_n, sel_b_n, strobe_edge, data, expect_a, expect_b}
  localparam logic [38:0] VEC [8] = '{
    {1'b0, 1'b1, 1'b1, 12'hA5C, 12'hA5C, 12'h000},  // R3
    {1'b1, 1'b0, 1'b1, 12'h3F1, 12'hA5C, 12'h3F1},  // R4
    {1'b0, 1'b0, 1'b1, 12'hFFF, 12'hFFF, 12'hFFF},  // R5
    {1'b1, 1'b1, 1'b1, 12'h123, 12'hFFF, 12'hFFF},  // R6
    {1'b0, 1'b0, 1'b0, 12'h456, 12'hFFF, 12'hFFF},  // R2
    {1'b0, 1'b1, 1'b1, 12'h800, 12'h800, 12'hFFF},  // R3
    {1'b1, 1'b0, 1'b1, 12'h7FF, 12'h800, 12'h7FF},  // R4
    {1'b0, 1'b0, 1'b1, 12'h000, 12'h000, 12'h000}   // R5
  };

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %03h expected %03h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_write(input logic sa, input logic sb, input logic edge_on, input logic [11:0] d);
    @(negedge clk);
    sel_a_n = sa; sel_b_n = sb; wr_data = d;
    ticks(3);
    if (edge_on) wr_strobe = 1'b1;
    ticks(6);
    wr_strobe = 1'b0;
    ticks(3);
    sel_a_n = 1'b1; sel_b_n = 1'b1;
    ticks(3);
  endtask

  initial begin
    @(posedge clk); #1;
    check("R1 reset a", code_a, 12'h000);
    check("R1 reset b", code_b, 12'h000);
    ticks(3);
    rst_n = 1'b1;
    ticks(2);
    check("R1 after release", code_a | code_b, 12'h000);

    for (int v = 0; v < 8; v++) begin
      do_write(VEC[v][38], VEC[v][37], VEC[v][36], VEC[v][35:24]);
      check($sformatf("R2-6 vector %0d a", v), code_a, VEC[v][23:12]);
      check($sformatf("R2-6 vector %0d b", v), code_b, VEC[v][11:0]);
    end

    // R8: latency of exactly three clock edges
    sel_a_n = 1'b0; wr_data = 12'h2B7;
    ticks(4);
    wr_strobe = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check("R8 unchanged after two edges", code_a, 12'h000);
    @(posedge clk); #1;
    check("R8 loaded on third edge", code_a, 12'h2B7);

    // R2: held-high strobe with changing data does not reload
    wr_data = 12'h999;
    ticks(5);
    wr_data = 12'h111;
    ticks(5);
    check("R2 level high no load", code_a, 12'h2B7);
    check("R2 level high b untouched", code_b, 12'h000);
    wr_strobe = 1'b0;
    sel_a_n = 1'b1;
    ticks(4);

    // R7: data and selects change in the same instant the strobe rises
    sel_a_n = 1'b0; sel_b_n = 1'b1; wr_data = 12'h0AA;
    ticks(4);
    wr_strobe = 1'b1; wr_data = 12'h555; sel_a_n = 1'b1; sel_b_n = 1'b0;
    ticks(6);
    check("R7 old word to a", code_a, 12'h0AA);
    check("R7 b not selected", code_b, 12'h000);
    wr_strobe = 1'b0; sel_b_n = 1'b1;
    ticks(3);

    // R1: reset in mid-run clears loaded codes
    rst_n = 1'b0;
    @(posedge clk); #1;
    check("R1 mid-run reset a", code_a, 12'h000);
    check("R1 mid-run reset b", code_b, 12'h000);
    rst_n = 1'b1;
    ticks(2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule